// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is an SPI master that a processor drives through a small byte-addressed register window. It has no FIFO. Software loads one byte into the transmit register and writes the start bit. The block then shifts that byte out on MOSI and, at the same time, shifts a byte in from MISO (or from its own MOSI when loopback is selected). When the eighth bit is in, the block raises a receive-ready flag and the interrupt line. Software reads the received byte, which clears both, and then starts the next byte.

The serial clock comes from the bus clock through a programmable divider. One SCK period is 4·(D+1) bus clocks, where D is the 8-bit divisor register. The mode register selects the clock idle level, the edge on which data is latched, and whether the frame goes out MSB-first or LSB-first. Chip-select handling is left to the surrounding system.

Top module: `spi_byte_master`

## Requirements
- R1: The register window uses these offsets. Mode is at 0 and reads back its low 5 bits; bits 7:5 read as 0. Receive data is at 1 and is read-only. Transmit data is at 2 and reads back. The clock divisor D is at 6 and reads back. The control register at 3 and the unused offsets 5 and 7 read as 0.
- R2: Writing a value with bit 0 set to offset 3 starts one 8-bit transfer of the transmit byte. The start is ignored when mode bit 3 (port enable) is clear or a transfer is already busy.
- R3: SCK toggles every H = 2·(D+1) bus clocks. Its first edge comes H cycles after the clock edge that accepts the start, and each transfer has 16 edges. Outside a transfer, SCK rests at the level of mode bit 1 (1 = idle high).
- R4: Mode bit 4 picks the latch edge. When it is 1, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. When it is 0, MOSI changes on every leading edge except the first, and MISO is sampled on the trailing edge. In both cases the first bit is on MOSI from the start of the transfer.
- R5: When mode bit 2 is set, bit 0 is sent and received first. When it is clear, bit 7 goes first.
- R6: At the clock edge of the 16th SCK edge, receive-ready (status bit 0) and the irq output go to 1, and the received byte appears at offset 1. Busy (status bit 1) stays at 1 for exactly one more cycle. irq always equals receive-ready.
- R7: A read strobe at offset 1 clears receive-ready and irq at that clock edge. If a transfer completes on the same edge, the completion wins. Receive-ready stays set until it is read.
- R8: When mode bit 0 is set, the receive shifter takes MOSI and ignores the MISO pin, so the received byte equals the transmitted byte.
- R9: The status register at offset 4 reads 0 when no transfer is busy and no received byte is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Byte offset within the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the offset on addr (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt, high while a received byte is pending |

## Verification
The start write is taken at one clock edge, called E0. SCK edge k (counting from 0) lands at E0+(k+1)·H. irq and receive-ready rise at E0+16·H, and busy falls at E0+16·H+1. The behavioural reference model counts cycles from the accepted start and compares SCK and irq one nanosecond after every rising edge. The status register is also probed in the three cycles around completion, so a flag that moves one cycle early or late is caught. A bench slave reacts to the actual SCK edges: it drives MISO and captures MOSI. This checks phase and bit order at the pins without assuming any internal timing.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 8;
  localparam int EDGES      = 2 * FRAME_BITS;
  localparam int EDGE_W     = $clog2(EDGES);
  localparam int ADDR_W     = 3;
  localparam int DIV_W      = 8;
  localparam int CNT_W      = DIV_W + 2;

  localparam logic [ADDR_W-1:0] OFF_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_CDIV = 3'd6;

  localparam int START_BIT  = 0;
  localparam int STAT_READY = 0;
  localparam int STAT_BUSY  = 1;

  typedef struct packed {
    logic lead_latch;
    logic enable;
    logic lsb_first;
    logic idle_high;
    logic loopback;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // last divider count of a half SCK period: 2*(D+1) - 1
  function automatic logic [CNT_W-1:0] half_last(input logic [DIV_W-1:0] d);
    return ({2'b00, d} << 1) + CNT_W'(1);
  endfunction

  function automatic logic out_bit(input logic [BYTE_W-1:0] sh, input logic lsb);
    return lsb ? sh[0] : sh[BYTE_W-1];
  endfunction

  function automatic logic [BYTE_W-1:0] out_advance(input logic [BYTE_W-1:0] sh,
                                                    input logic lsb);
    return lsb ? {1'b0, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], 1'b0};
  endfunction

  function automatic logic [BYTE_W-1:0] in_accept(input logic [BYTE_W-1:0] sh,
                                                  input logic b, input logic lsb);
    return lsb ? {b, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_byte_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = half_last(divisor);
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              cpha,
  input  logic              lsb,
  input  logic              ser_in,
  output logic              running,
  output logic              busy,
  output logic              phase,
  output logic              ser_out,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic              run_q, tail_q, phase_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BYTE_W-1:0] tx_sh, rx_sh, rx_q;
  logic              sample_now, shift_now;
  logic [BYTE_W-1:0] rx_next;

  assign sample_now = tick && (cpha ? edge_q[0] : ~edge_q[0]);
  assign shift_now  = tick && !sample_now && !(cpha && edge_q == '0);
  assign done       = tick && (edge_q == LAST_EDGE);
  assign rx_next    = in_accept(rx_sh, ser_in, lsb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      tail_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
    end else begin
      tail_q <= done;
      if (start) begin
        run_q   <= 1'b1;
        phase_q <= 1'b0;
        edge_q  <= '0;
        tx_sh   <= tx_byte;
        rx_sh   <= '0;
      end else if (tick) begin
        edge_q  <= edge_q + EDGE_W'(1);
        phase_q <= ~phase_q;
        if (sample_now) rx_sh <= rx_next;
        if (shift_now)  tx_sh <= out_advance(tx_sh, lsb);
        if (done) begin
          run_q <= 1'b0;
          rx_q  <= sample_now ? rx_next : rx_sh;
        end
      end
    end
  end

  assign running = run_q;
  assign busy    = run_q | tail_q;
  assign phase   = phase_q;
  assign ser_out = out_bit(tx_sh, lsb);
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_reg_window.sv
module spi_reg_window
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] rdata,
  output mode_t             mode,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [DIV_W-1:0]  divisor,
  output logic              start,
  output logic              rx_ready
);
  mode_t             mode_q;
  logic [BYTE_W-1:0] tx_q;
  logic [DIV_W-1:0]  div_q;
  logic              ready_q;

  assign start = wr_en && (addr == OFF_CTRL) && wdata[START_BIT]
                 && mode_q.enable && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tx_q    <= '0;
      div_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (wr_en && addr == OFF_MODE) mode_q <= mode_t'(wdata[MODE_W-1:0]);
      if (wr_en && addr == OFF_TXD)  tx_q   <= wdata;
      if (wr_en && addr == OFF_CDIV) div_q  <= wdata[DIV_W-1:0];
      if (done)                             ready_q <= 1'b1;
      else if (rd_en && addr == OFF_RXD)    ready_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_MODE: rdata[MODE_W-1:0] = mode_q;
      OFF_RXD:  rdata = rx_byte;
      OFF_TXD:  rdata = tx_q;
      OFF_STAT: begin
        rdata[STAT_BUSY]  = busy;
        rdata[STAT_READY] = ready_q;
      end
      OFF_CDIV: rdata[DIV_W-1:0] = div_q;
      default:  rdata = '0;
    endcase
  end

  assign mode     = mode_q;
  assign tx_byte  = tx_q;
  assign divisor  = div_q;
  assign rx_ready = ready_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  mode_t             mode;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  divisor;
  logic              start_accept, edge_tick, xfer_done;
  logic              running, busy, phase, ser_out, ser_in, rx_ready;

  spi_reg_window u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .done(xfer_done), .rx_byte(rx_byte),
    .rdata(rdata), .mode(mode), .tx_byte(tx_byte), .divisor(divisor),
    .start(start_accept), .rx_ready(rx_ready)
  );

  spi_clk_div u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .divisor(divisor), .tick(edge_tick)
  );

  assign ser_in = mode.loopback ? ser_out : miso;

  spi_shift_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_accept), .tx_byte(tx_byte),
    .tick(edge_tick), .cpha(~mode.lead_latch), .lsb(mode.lsb_first),
    .ser_in(ser_in), .running(running), .busy(busy), .phase(phase),
    .ser_out(ser_out), .done(xfer_done), .rx_byte(rx_byte)
  );

  assign sck  = mode.idle_high ^ phase;
  assign mosi = ser_out;
  assign irq  = rx_ready;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic              sck,
  input logic              irq,
  input logic              busy,
  input logic              edge_tick,
  input logic              xfer_done,
  input mode_t             mode
);
  assert_start_from_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == OFF_CTRL && wdata[START_BIT]));

  assert_sck_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == mode.idle_high);

  assert_sck_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_tick && !(wr_en && addr == OFF_MODE)) |=> $stable(sck));

  assert_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq && busy);

  assert_busy_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> ##1 !busy);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_RXD && !xfer_done) |=> !irq);

  assert_status_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_STAT && !busy && !irq) |-> rdata == '0);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sck(sck), .irq(irq), .busy(busy),
  .edge_tick(edge_tick), .xfer_done(xfer_done), .mode(mode)
);

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sck, mosi, miso, irq;

  always #2.5 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] sh_mode = 8'h00, sh_cdm = 8'h00, sh_tx = 8'h00;

  // behavioural reference: cycle counts since the accepted start
  bit m_busy = 0, m_ready = 0, was_busy;
  int n = 0, H = 2;
  logic [7:0] m_rx_exp;

  // bench slave
  bit s_on = 0, s_first = 1;
  int s_j = 0, s_samples = 0;
  logic [7:0] s_byte = 8'h00, s_cap = 8'h00;
  bit leading, cpha_b;

  function automatic void chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; n = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        n++;
        if (n == 16*H + 1) m_busy = 0;
      end
      if (rd_en && addr == 3'd1) m_ready = 0;
      if (m_busy && n == 16*H) m_ready = 1;
      if (!was_busy && wr_en && addr == 3'd3 && wdata[0] && sh_mode[3]) begin
        m_busy = 1; n = 0; H = 2*(int'(sh_cdm) + 1);
        m_rx_exp = sh_mode[0] ? sh_tx : s_byte;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R3 sck", {7'd0, sck},
          {7'd0, m_busy ? (sh_mode[1] ^ (((n / H) % 2) == 1)) : sh_mode[1]});
      chk("R6 irq", {7'd0, irq}, {7'd0, m_ready});
    end
  end

  always @* miso = (s_j < 8) ? (sh_mode[2] ? s_byte[s_j] : s_byte[7 - s_j]) : 1'b0;

  always @(sck) begin
    if (rst_n && s_on) begin
      leading = (sck != sh_mode[1]);
      cpha_b  = ~sh_mode[4];
      if (cpha_b ? !leading : leading) begin
        if (s_samples < 8) s_cap[sh_mode[2] ? s_samples : 7 - s_samples] = mosi;
        s_samples++;
      end else if (cpha_b && s_first) s_first = 0;
      else s_j++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    if (a == 3'd0) sh_mode = d;
    if (a == 3'd2) sh_tx = d;
    if (a == 3'd6) sh_cdm = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic arm(input logic [7:0] m, input logic [7:0] c,
                     input logic [7:0] t, input logic [7:0] s);
    wr(3'd0, m); wr(3'd6, c); wr(3'd2, t);
    s_byte = s; s_j = 0; s_samples = 0; s_first = 1; s_cap = 8'h00; s_on = 1;
  endtask

  task automatic xfer(input string tag, input logic [7:0] m, input logic [7:0] c,
                      input logic [7:0] t, input logic [7:0] s);
    logic [7:0] v;
    int hp;
    hp = 2*(int'(c) + 1);
    arm(m, c, t, s);
    wr(3'd3, 8'h01);
    repeat (16*hp + 2) @(negedge clk);
    chk({tag, " R6 irq after frame"}, {7'd0, irq}, 8'h01);
    rd(3'd4, v); chk({tag, " R6 status ready"}, v, 8'h01);
    chk({tag, " mosi seen by slave"}, s_cap, t);
    rd(3'd1, v); chk({tag, " rx byte"}, v, m[0] ? t : s);
    @(negedge clk);
    chk({tag, " R7 irq cleared"}, {7'd0, irq}, 8'h00);
    rd(3'd4, v); chk({tag, " R9 status idle"}, v, 8'h00);
    s_on = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset irq", {7'd0, irq}, 8'h00);
    chk("R3 reset sck", {7'd0, sck}, 8'h00);
    rd(3'd4, v); chk("R9 reset status", v, 8'h00);

    // R1 register window
    wr(3'd0, 8'hE6); rd(3'd0, v); chk("R1 mode readback", v, 8'h06);
    wr(3'd2, 8'h5C); rd(3'd2, v); chk("R1 tx readback", v, 8'h5C);
    wr(3'd6, 8'hA7); rd(3'd6, v); chk("R1 divisor readback", v, 8'hA7);
    rd(3'd3, v); chk("R1 control reads zero", v, 8'h00);
    rd(3'd5, v); chk("R1 offset 5 reads zero", v, 8'h00);
    wr(3'd0, 8'h00);

    xfer("R4 lead-latch idle-low",  8'h18, 8'd0, 8'hA5, 8'h3C);
    xfer("R4 trail-latch idle-low", 8'h08, 8'd1, 8'h5A, 8'hC3);
    xfer("R3 lead-latch idle-high", 8'h1A, 8'd2, 8'h81, 8'h7E);
    xfer("R5 lsb trail idle-high",  8'h0E, 8'd3, 8'h01, 8'h80);
    xfer("R5 lsb lead idle-low",    8'h1C, 8'd0, 8'hB4, 8'h2D);
    xfer("R8 loopback msb",         8'h19, 8'd0, 8'h96, 8'h00);
    xfer("R8 loopback lsb",         8'h0F, 8'd1, 8'h3E, 8'hFF);
    xfer("R3 max divisor",          8'h18, 8'd255, 8'h0F, 8'hF0);

    // R2: start ignored with port disabled
    arm(8'h10, 8'd0, 8'h55, 8'h00);
    wr(3'd3, 8'h01);
    repeat (50) @(negedge clk);
    rd(3'd4, v); chk("R2 disabled start ignored", v, 8'h00);
    chk("R2 disabled no irq", {7'd0, irq}, 8'h00);
    s_on = 0;

    // R2: second start during a transfer ignored (model keeps first timing)
    arm(8'h18, 8'd1, 8'hC9, 8'h6B);
    wr(3'd3, 8'h01);
    repeat (10) @(negedge clk);
    wr(3'd3, 8'h01);
    repeat (16*4) @(negedge clk);
    rd(3'd1, v); chk("R2 restart ignored rx", v, 8'h6B);
    s_on = 0;

    // R6: status around completion, D=0 so H=2, done at E0+32
    arm(8'h18, 8'd0, 8'h11, 8'h22);
    wr(3'd3, 8'h01);
    repeat (31) @(negedge clk);
    addr = 3'd4;
    #1 chk("R6 busy before done", rdata, 8'h02);
    @(negedge clk);
    #1 chk("R6 ready and busy", rdata, 8'h03);
    @(negedge clk);
    #1 chk("R6 busy drops one cycle later", rdata, 8'h01);
    // R7: pending byte stays until read
    repeat (20) @(negedge clk);
    chk("R7 irq held until read", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R7 rx byte", v, 8'h22);
    @(negedge clk);
    chk("R7 irq after read", {7'd0, irq}, 8'h00);
    s_on = 0;

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule